// File: doc/BRIEF.md
# Accumulator-Based Sequential ALU

This block is a word-wide arithmetic and logic unit organised around three registers: an accumulator (AC), a multiplier-quotient register (MQ) and a data register (DR). A single combinational adder/logic stage reads AC and DR and writes its result back into AC. Addition, subtraction, the bitwise operations and one-position shifts of the AC.MQ pair each complete in one clock cycle. Multiplication and division are multicycle. They reuse the same adder, one bit per cycle, with AC and MQ chained as a double-length shift register in which AC holds the upper half.

Software or a sequencer loads the operands through a shared data bus with one load strobe per register. It selects an operation on a 4-bit opcode and pulses start. Busy covers the multicycle operations, done pulses once for every accepted operation, and a divide-error flag reports a zero divisor. The results are read from the AC and MQ outputs. The word width is a parameter with a default of 16 bits. All arithmetic is unsigned.

Top module: `seq_acc_alu`

## Requirements
- R1: After reset, AC, MQ and DR are zero and busy, done and div_err are low.
- R2: When busy and start are both low, each of ld_ac, ld_mq and ld_dr writes ld_data into its register at the clock edge. A load strobe has no effect in a cycle where busy or start is high.
- R3: Opcode 0 sets AC to (AC + DR) mod 2^W, and opcode 1 sets AC to (AC - DR) mod 2^W. MQ is unchanged. Busy stays low, and done is high in the cycle right after the start edge.
- R4: Opcode 2 sets AC to AC AND DR, opcode 3 to AC OR DR, opcode 4 to AC XOR DR, and opcode 5 to NOT AC. Each completes in one cycle and leaves MQ unchanged.
- R5: Opcode 8 shifts the 2W-bit value {AC,MQ} left by one with a 0 entering MQ bit 0. Opcode 9 shifts it right by one with a 0 entering AC bit W-1. Each completes in one cycle.
- R6: Opcode 6 leaves the unsigned 2W-bit product DR × MQ in {AC,MQ}, with AC holding the upper half, whatever AC held before the operation.
- R7: Opcode 7 with a nonzero DR leaves the unsigned quotient MQ / DR in MQ and the remainder in AC, whatever AC held before the operation.
- R8: For opcode 6, and for opcode 7 with a nonzero DR, busy is high for exactly W cycles after the start edge. Done is then high for one cycle while busy is low.
- R9: A start pulse while busy is high is ignored. It does not alter the running result, its timing, or produce an extra done.
- R10: Opcode 7 with DR equal to zero raises div_err and done in the cycle after the start edge. It leaves AC and MQ unchanged and keeps busy low. div_err clears at the next accepted start.
- R11: Opcodes 10 to 15 complete in one cycle with done and change neither AC nor MQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_data | input | W | Shared load data for AC, MQ and DR |
| ld_ac | input | 1 | Load AC from ld_data |
| ld_mq | input | 1 | Load MQ from ld_data |
| ld_dr | input | 1 | Load DR from ld_data |
| start | input | 1 | Begin the operation on opcode |
| opcode | input | 4 | Operation select |
| busy | output | 1 | Multicycle operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last division had a zero divisor |
| ac_out | output | W | Accumulator contents |
| mq_out | output | W | Multiplier-quotient register contents |

## Verification
Addition and subtraction are driven with values that wrap past all-ones and below zero. This separates modular results from results that saturate or are truncated wrongly. Multiplication is run with all-ones operands, a zero multiplier, small values and a stale nonzero AC. These expose a dropped carry out of the adder, a missing AC clear, and mistakes in the shift direction. Division is run with a dividend smaller than the divisor, a divisor of one, equal operands and a general case, which together exercise both the restore path and the keep path of each step. Shifts use patterns whose set bits cross the AC/MQ boundary, so that a pair shifted as two separate halves shows up.

// File: rtl/sal_pkg.sv
package sal_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOT = 4'd5,
    OP_MUL = 4'd6,
    OP_DIV = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9
  } sal_op_e;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_NOT,
    FN_MSTEP,
    FN_DSTEP
  } sal_fn_e;

  typedef enum logic [2:0] {
    CMD_HOLD,
    CMD_WR_AC,
    CMD_SHL,
    CMD_SHR,
    CMD_CLR_AC,
    CMD_MSTEP,
    CMD_DSTEP
  } sal_cmd_e;

endpackage

// File: rtl/sal_arith.sv
module sal_arith
  import sal_pkg::*;
#(
  parameter int W = 16
) (
  input  sal_fn_e        fn,
  input  logic [W-1:0]   ac,
  input  logic [W-1:0]   dr,
  input  logic           mq_lsb,
  input  logic           mq_msb,
  output logic [W-1:0]   ac_new,
  output logic           bit_new
);

  localparam int AW = W + 1;

  logic [AW-1:0] opa;
  logic [AW-1:0] opb;
  logic          sub;
  logic [AW-1:0] sum;

  // Operand selection for the single shared adder
  always_comb begin
    opa = {1'b0, ac};
    opb = {1'b0, dr};
    sub = 1'b0;
    case (fn)
      FN_SUB:   sub = 1'b1;
      FN_MSTEP: opb = mq_lsb ? {1'b0, dr} : '0;
      FN_DSTEP: begin
        opa = {ac, mq_msb};
        sub = 1'b1;
      end
      default: ;
    endcase
  end

  assign sum = opa + (sub ? ~opb : opb) + {{(AW-1){1'b0}}, sub};

  // Result selection
  always_comb begin
    ac_new  = sum[W-1:0];
    bit_new = 1'b0;
    case (fn)
      FN_AND: ac_new = ac & dr;
      FN_OR:  ac_new = ac | dr;
      FN_XOR: ac_new = ac ^ dr;
      FN_NOT: ac_new = ~ac;
      FN_MSTEP: begin
        ac_new  = sum[W:1];
        bit_new = sum[0];
      end
      FN_DSTEP: begin
        ac_new  = sum[W] ? opa[W-1:0] : sum[W-1:0];
        bit_new = ~sum[W];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sal_ctrl.sv
module sal_ctrl
  import sal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] opcode,
  input  logic       dr_zero,
  output logic       busy,
  output logic       done,
  output logic       div_err,
  output logic       load_ok,
  output sal_cmd_e   cmd,
  output sal_fn_e    fn
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          err_q,  err_d;
  logic          div_q,  div_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  sal_op_e       op;

  assign op = sal_op_e'(opcode);

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    err_d  = err_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    cmd    = CMD_HOLD;
    fn     = FN_ADD;
    if (busy_q) begin
      cmd   = div_q ? CMD_DSTEP : CMD_MSTEP;
      fn    = div_q ? FN_DSTEP : FN_MSTEP;
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      err_d  = 1'b0;
      done_d = 1'b1;
      case (op)
        OP_ADD: begin cmd = CMD_WR_AC; fn = FN_ADD; end
        OP_SUB: begin cmd = CMD_WR_AC; fn = FN_SUB; end
        OP_AND: begin cmd = CMD_WR_AC; fn = FN_AND; end
        OP_OR:  begin cmd = CMD_WR_AC; fn = FN_OR;  end
        OP_XOR: begin cmd = CMD_WR_AC; fn = FN_XOR; end
        OP_NOT: begin cmd = CMD_WR_AC; fn = FN_NOT; end
        OP_SHL: cmd = CMD_SHL;
        OP_SHR: cmd = CMD_SHR;
        OP_MUL: begin
          cmd    = CMD_CLR_AC;
          busy_d = 1'b1;
          done_d = 1'b0;
          div_d  = 1'b0;
          cnt_d  = CNT_INIT;
        end
        OP_DIV: begin
          if (dr_zero) begin
            err_d = 1'b1;
          end else begin
            cmd    = CMD_CLR_AC;
            busy_d = 1'b1;
            done_d = 1'b0;
            div_d  = 1'b1;
            cnt_d  = CNT_INIT;
          end
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign div_err = err_q;
  assign load_ok = !busy_q && !start;

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  // R8
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));

  // R8
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == CNT_ONE) |=> (done_q && !busy_q));

  // R9
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != CNT_ONE) |=> (busy_q && !done_q));

  // R10
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q && op == OP_DIV && dr_zero) |=> (err_q && done_q && !busy_q));

endmodule

// File: rtl/sal_regs.sv
module sal_regs
  import sal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sal_cmd_e     cmd,
  input  logic         ld_ac,
  input  logic         ld_mq,
  input  logic         ld_dr,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] ac_new,
  input  logic         bit_new,
  output logic [W-1:0] ac_q,
  output logic [W-1:0] mq_q,
  output logic [W-1:0] dr_q
);

  logic [W-1:0] ac_d, mq_d, dr_d;
  logic         ac_en, mq_en, dr_en;

  // Next values and clock enables
  always_comb begin
    ac_d  = ac_q;
    mq_d  = mq_q;
    dr_d  = ld_data;
    ac_en = ld_ac;
    mq_en = ld_mq;
    dr_en = ld_dr;
    if (ld_ac) ac_d = ld_data;
    if (ld_mq) mq_d = ld_data;
    case (cmd)
      CMD_WR_AC: begin
        ac_d  = ac_new;
        ac_en = 1'b1;
      end
      CMD_SHL: begin
        {ac_d, mq_d} = {ac_q, mq_q} << 1;
        ac_en = 1'b1;
        mq_en = 1'b1;
      end
      CMD_SHR: begin
        {ac_d, mq_d} = {ac_q, mq_q} >> 1;
        ac_en = 1'b1;
        mq_en = 1'b1;
      end
      CMD_CLR_AC: begin
        ac_d  = '0;
        ac_en = 1'b1;
      end
      CMD_MSTEP: begin
        ac_d  = ac_new;
        mq_d  = {bit_new, mq_q[W-1:1]};
        ac_en = 1'b1;
        mq_en = 1'b1;
      end
      CMD_DSTEP: begin
        ac_d  = ac_new;
        mq_d  = {mq_q[W-2:0], bit_new};
        ac_en = 1'b1;
        mq_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      mq_q <= '0;
      dr_q <= '0;
    end else begin
      if (ac_en) ac_q <= ac_d;
      if (mq_en) mq_q <= mq_d;
      if (dr_en) dr_q <= dr_d;
    end
  end

  // R7
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DSTEP) |=> (ac_q < dr_q));

  // R2
  dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MSTEP || cmd == CMD_DSTEP) |=> $stable(dr_q));

  // R5
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SHL) |=> (mq_q[0] == 1'b0));

  // R5
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SHR) |=> (ac_q[W-1] == 1'b0));

  // R6
  clr_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CLR_AC) |=> (ac_q == '0));

endmodule

// File: rtl/seq_acc_alu.sv
module seq_acc_alu
  import sal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ld_data,
  input  logic         ld_ac,
  input  logic         ld_mq,
  input  logic         ld_dr,
  input  logic         start,
  input  logic [3:0]   opcode,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] mq_out
);

  logic         rst_s1, rst_sync_n;
  logic         load_ok;
  sal_cmd_e     cmd;
  sal_fn_e      fn;
  logic [W-1:0] ac_q, mq_q, dr_q;
  logic [W-1:0] ac_new;
  logic         bit_new;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  sal_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .opcode  (opcode),
    .dr_zero (dr_q == '0),
    .busy    (busy),
    .done    (done),
    .div_err (div_err),
    .load_ok (load_ok),
    .cmd     (cmd),
    .fn      (fn)
  );

  sal_arith #(.W(W)) u_arith (
    .fn      (fn),
    .ac      (ac_q),
    .dr      (dr_q),
    .mq_lsb  (mq_q[0]),
    .mq_msb  (mq_q[W-1]),
    .ac_new  (ac_new),
    .bit_new (bit_new)
  );

  sal_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd     (cmd),
    .ld_ac   (ld_ac && load_ok),
    .ld_mq   (ld_mq && load_ok),
    .ld_dr   (ld_dr && load_ok),
    .ld_data (ld_data),
    .ac_new  (ac_new),
    .bit_new (bit_new),
    .ac_q    (ac_q),
    .mq_q    (mq_q),
    .dr_q    (dr_q)
  );

  assign ac_out = ac_q;
  assign mq_out = mq_q;

endmodule

// File: tb/seq_acc_alu_bench.sv
module seq_acc_alu_bench;

  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic         ld_ac = 1'b0, ld_mq = 1'b0, ld_dr = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   opcode = '0;
  logic         busy, done, div_err;
  logic [W-1:0] ac_out, mq_out;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_acc_alu #(.W(W)) u_seq_acc_alu (
    .clk(clk), .rst_n(rst_n), .ld_data(ld_data), .ld_ac(ld_ac), .ld_mq(ld_mq),
    .ld_dr(ld_dr), .start(start), .opcode(opcode), .busy(busy), .done(done),
    .div_err(div_err), .ac_out(ac_out), .mq_out(mq_out)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_all(input logic [W-1:0] a, input logic [W-1:0] m, input logic [W-1:0] d);
    @(negedge clk); ld_data = a; ld_ac = 1'b1;
    @(negedge clk); ld_ac = 1'b0; ld_data = m; ld_mq = 1'b1;
    @(negedge clk); ld_mq = 1'b0; ld_data = d; ld_dr = 1'b1;
    @(negedge clk); ld_dr = 1'b0;
  endtask

  // Pulse start, then count sampled cycles until done; lat = busy-high samples
  task automatic run_op(input logic [3:0] op, output int lat);
    @(negedge clk); opcode = op; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      if (busy) lat++;
      else lat = lat + 2000;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 ac", ac_out, 0);
    chk("R1 mq", mq_out, 0);
    chk("R1 busy/done/err", {busy, done, div_err}, 0);
  endtask

  task automatic t_load;
    load_all(16'hA5C3, 16'h3C5A, 16'h0001);
    chk("R2 ac load", ac_out, 16'hA5C3);
    chk("R2 mq load", mq_out, 16'h3C5A);
  endtask

  task automatic t_addsub;
    int lat;
    load_all(16'h1234, 16'h7777, 16'h0F0F);
    run_op(4'd0, lat);
    chk("R3 add", ac_out, 16'h2143);
    chk("R3 add latency", lat, 0);
    chk("R3 mq kept", mq_out, 16'h7777);
    load_all(ONES, 16'h7777, 16'h0001);
    run_op(4'd0, lat);
    chk("R3 add wrap", ac_out, 0);
    load_all(16'h0000, 16'h7777, 16'h0001);
    run_op(4'd1, lat);
    chk("R3 sub wrap", ac_out, ONES);
    load_all(16'h9000, 16'h7777, 16'h1234);
    run_op(4'd1, lat);
    chk("R3 sub", ac_out, 16'h7DCC);
  endtask

  task automatic t_logic;
    int lat;
    load_all(16'hF0CC, 16'h1111, 16'hAAAA);
    run_op(4'd2, lat);
    chk("R4 and", ac_out, 16'hA088);
    load_all(16'hF0CC, 16'h1111, 16'hAAAA);
    run_op(4'd3, lat);
    chk("R4 or", ac_out, 16'hFAEE);
    load_all(16'hF0CC, 16'h1111, 16'hAAAA);
    run_op(4'd4, lat);
    chk("R4 xor", ac_out, 16'h5A66);
    run_op(4'd5, lat);
    chk("R4 not", ac_out, 16'hA599);
    chk("R4 mq kept", mq_out, 16'h1111);
  endtask

  task automatic t_shift;
    int lat;
    load_all(16'h8001, 16'h8001, 16'h0);
    run_op(4'd8, lat);
    chk("R5 shl pair", {ac_out, mq_out}, 32'h0003_0002);
    load_all(16'h8001, 16'h0000, 16'h0);
    run_op(4'd9, lat);
    chk("R5 shr pair", {ac_out, mq_out}, 32'h4000_8000);
    chk("R5 latency", lat, 0);
  endtask

  task automatic t_mul(input logic [W-1:0] a0, input logic [W-1:0] m, input logic [W-1:0] d);
    int lat;
    logic [31:0] exp;
    exp = 32'(m) * 32'(d);
    load_all(a0, m, d);
    run_op(4'd6, lat);
    chk($sformatf("R6 mul %0h*%0h", m, d), {ac_out, mq_out}, exp);
    chk("R8 mul busy cycles", lat, W);
    chk("R8 mul done high, busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
  endtask

  task automatic t_div(input logic [W-1:0] a0, input logic [W-1:0] m, input logic [W-1:0] d);
    int lat;
    load_all(a0, m, d);
    run_op(4'd7, lat);
    chk($sformatf("R7 div q %0h/%0h", m, d), mq_out, m / d);
    chk($sformatf("R7 div r %0h/%0h", m, d), ac_out, m % d);
    chk("R8 div busy cycles", lat, W);
  endtask

  task automatic t_start_ignored;
    int lat;
    load_all(16'h0, 16'h00FF, 16'h0101);
    @(negedge clk); opcode = 4'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    opcode = 4'd0; start = 1'b1;
    @(negedge clk); start = 1'b0; opcode = 4'd6;
    lat = 4;
    while (!done && lat < 1000) begin lat++; @(negedge clk); end
    chk("R9 result kept", {ac_out, mq_out}, 32'h0000_FFFF);
    chk("R9 timing kept", lat, W);
    @(negedge clk);
    chk("R9 no extra done", {done, busy}, 0);
  endtask

  task automatic t_load_ignored;
    int lat;
    load_all(16'h0, 16'h0003, 16'h0005);
    @(negedge clk); opcode = 4'd6; start = 1'b1;
    ld_data = 16'h0077; ld_dr = 1'b1;
    @(negedge clk); start = 1'b0;
    ld_ac = 1'b1; ld_mq = 1'b1;
    @(negedge clk); ld_ac = 1'b0; ld_mq = 1'b0; ld_dr = 1'b0;
    lat = 2;
    while (!done && lat < 1000) begin lat++; @(negedge clk); end
    chk("R2 loads ignored while busy", {ac_out, mq_out}, 32'd15);
    // bring DR out: AC=0 then ADD gives AC=DR
    @(negedge clk); ld_data = '0; ld_ac = 1'b1;
    @(negedge clk); ld_ac = 1'b0;
    run_op(4'd0, lat);
    chk("R2 dr untouched", ac_out, 16'h0005);
  endtask

  task automatic t_divzero;
    int lat;
    load_all(16'h0055, 16'h0099, 16'h0000);
    run_op(4'd7, lat);
    chk("R10 err with done", {div_err, done, busy}, 3'b110);
    chk("R10 latency", lat, 0);
    chk("R10 regs kept", {ac_out, mq_out}, 32'h0055_0099);
    run_op(4'd0, lat);
    chk("R10 err clears", div_err, 0);
  endtask

  task automatic t_undef;
    int lat;
    load_all(16'h1357, 16'h2468, 16'h1111);
    run_op(4'd12, lat);
    chk("R11 undefined op", {ac_out, mq_out}, 32'h1357_2468);
    chk("R11 done", lat, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_addsub();
    t_logic();
    t_shift();
    t_mul(16'hBEEF, ONES, ONES);
    t_mul(16'h1234, 16'h0000, 16'h4321);
    t_mul(16'h0000, 16'd3, 16'd5);
    t_mul(16'hFFFF, 16'h1234, 16'h5678);
    t_div(16'hBEEF, 16'd100, 16'd7);
    t_div(16'h0000, ONES, 16'd1);
    t_div(16'h0001, 16'd5, 16'd9);
    t_div(16'h0000, ONES, ONES);
    t_div(16'h7777, 16'hC350, 16'h00FB);
    t_start_ignored();
    t_load_ignored();
    t_divzero();
    t_undef();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule